// File: doc/BRIEF.md
# Shadow-Loaded Raster Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes of a raster display, together with the pixel column and row of the current active pixel. Each line runs through four phases in order: active pixels, front porch, sync pulse and back porch. The frame runs through the same four phases counted in lines. All eight lengths can be programmed. Each of the three strobes has its own polarity bit.

Software writes every setting through a small register port into a shadow copy. Arming the load bit copies the shadow into the live set at the next frame boundary, so a frame never mixes old and new settings. Starting the generator also counts as a frame boundary. Clearing the enable bit lets the current frame finish. The enable bit reads back as set until the last pixel of that frame has gone out, so software can poll it. A one-cycle vertical-blank pulse feeds a sticky status bit and a maskable interrupt.

Top module: `disp_timing_gen`

## Requirements
- R1: One line lasts hact+hfp+hsw+hbp cycles. Data enable is active for the first hact cycles of an active line. Hsync becomes active exactly hfp cycles after data enable ends and stays active for hsw cycles of every line.
- R2: One frame lasts (hact+hfp+hsw+hbp)*(vact+vfp+vsw+vbp) cycles. Data enable is active on the first vact lines only. Vsync is active for vsw whole lines, which start vfp lines after the last active line.
- R3: Control bit 2 inverts hsync, bit 3 inverts vsync and bit 4 inverts data enable. A set bit makes that signal active low. The bits take effect through the shadow load.
- R4: Writes to the timing fields (addresses 6..13, in the order hact, hfp, hsw, hbp, vact, vfp, vsw, vbp) and to the frame base (address 5) change only the shadow. Reads of these addresses return the shadow. Output timing and the frame_base port stay unchanged until the next commit.
- R5: Writing 1 to control bit 1 arms a load. Bit 1 reads 1 until the commit at the next frame end, or at start, and then reads 0. Writing 0 does not cancel an armed load.
- R6: Control bit 0 enables the generator. Setting it while stopped starts a frame at column 0, row 0, and commits any armed load. Clearing it lets the current frame complete. Bit 0 reads 1 until the frame's last cycle has passed. If the bit is cleared during the vertical-blank pulse cycle, it reads 1 for exactly (vfp+vsw+vbp)*htot-1 further cycles.
- R7: While stopped, hsync, vsync and data enable sit at their inactive levels (the invert bit value), and no vertical-blank pulse occurs.
- R8: Address 0 writes the control register directly, address 1 ORs the write data into it, and address 2 clears the bits that are set in the write data. Control bit 5 is a soft reset. While it is set, the shadow and live registers, the frame base, the enable, the load, the status and the interrupt enable all return to their defaults, and the generator stops.
- R9: The vblank output pulses for exactly one cycle, at column 0 of line vact. The pulse sets status bit 0 (address 3), and writing 1 there clears it; if both happen in the same cycle, the set wins. irq is active when that bit and the enable bit at address 4 are both 1.
- R10: While data enable is active, pix_x counts 0..hact-1 along the line and pix_y gives the active line number, from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for reg_addr (combinational) |
| hsync | output | 1 | Horizontal sync, polarity applied |
| vsync | output | 1 | Vertical sync, polarity applied |
| de | output | 1 | Data enable, polarity applied |
| pix_x | output | CW+2 | Current column |
| pix_y | output | CW+2 | Current row |
| frame_base | output | DW | Live frame base address |
| vblank | output | 1 | One-cycle pulse at the start of vertical front porch |
| irq | output | 1 | Vertical-blank interrupt |

## Verification
The hardest case is a register change that lands in the middle of a frame. Its effect has to be held back until that frame ends, while an armed load must still take effect at that same boundary. The bench therefore writes a new active width and frame base right after a vblank pulse, measures one whole frame to show that the old values still apply, and only then arms the load. The disable case is timed the same way: the enable is cleared during a vblank pulse, so the exact number of cycles until the enable reads 0 is known in advance. Randomly chosen modes with random polarities confirm the line and frame cycle counts.

// File: rtl/tg_pkg.sv
package tg_pkg;
    localparam int ADDR_W   = 4;
    localparam int N_FIELDS = 8;
    localparam int CTRL_W   = 6;

    localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
    localparam logic [ADDR_W-1:0] A_SET   = 4'd1;
    localparam logic [ADDR_W-1:0] A_CLR   = 4'd2;
    localparam logic [ADDR_W-1:0] A_STAT  = 4'd3;
    localparam logic [ADDR_W-1:0] A_IRQEN = 4'd4;
    localparam logic [ADDR_W-1:0] A_BASE  = 4'd5;
    localparam logic [ADDR_W-1:0] A_TIM0  = 4'd6;

    localparam int B_EN    = 0;
    localparam int B_LOAD  = 1;
    localparam int B_INVH  = 2;
    localparam int B_INVV  = 3;
    localparam int B_INVDE = 4;
    localparam int B_SRST  = 5;

    localparam int F_HACT = 0;
    localparam int F_HFP  = 1;
    localparam int F_HSW  = 2;
    localparam int F_HBP  = 3;
    localparam int F_VACT = 4;
    localparam int F_VFP  = 5;
    localparam int F_VSW  = 6;
    localparam int F_VBP  = 7;
endpackage

// File: rtl/tg_regs.sv
module tg_regs
    import tg_pkg::*;
#(
    parameter int CW = 12,
    parameter int DW = 32,
    parameter logic [N_FIELDS-1:0][CW-1:0] DEF_TIM = '0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DW-1:0]                wdata,
    output logic [DW-1:0]                rdata,
    input  logic                         frame_end,
    input  logic                         vblank,
    output logic [N_FIELDS-1:0][CW-1:0]  live_tim,
    output logic [2:0]                   live_inv,
    output logic [DW-1:0]                live_base,
    output logic                         run,
    output logic                         srst,
    output logic                         load_pend,
    output logic                         sticky,
    output logic                         irq
);
    typedef struct packed {
        logic [N_FIELDS-1:0][CW-1:0] sh_tim;
        logic [N_FIELDS-1:0][CW-1:0] lv_tim;
        logic [2:0]                  sh_inv;
        logic [2:0]                  lv_inv;
        logic [DW-1:0]               sh_base;
        logic [DW-1:0]               lv_base;
        logic                        en;
        logic                        load;
        logic                        srst;
        logic                        run;
        logic                        sticky;
        logic                        irq_en;
    } st_t;

    function automatic st_t defaults();
        st_t s;
        s        = '0;
        s.sh_tim = DEF_TIM;
        s.lv_tim = DEF_TIM;
        return s;
    endfunction

    st_t st_d, st_q;
    logic [CTRL_W-1:0] ctrl_v;
    logic w_ctrl, load_set, start, fend;

    always_comb begin
        st_d     = st_q;
        ctrl_v   = {st_q.srst, st_q.sh_inv, st_q.load, st_q.en};
        w_ctrl   = we && (addr == A_CTRL || addr == A_SET || addr == A_CLR);
        load_set = w_ctrl && (addr != A_CLR) && wdata[B_LOAD];
        if (we) begin
            case (addr)
                A_CTRL:  ctrl_v = wdata[CTRL_W-1:0];
                A_SET:   ctrl_v = ctrl_v | wdata[CTRL_W-1:0];
                A_CLR:   ctrl_v = ctrl_v & ~wdata[CTRL_W-1:0];
                A_STAT:  if (wdata[0]) st_d.sticky = 1'b0;
                A_IRQEN: st_d.irq_en = wdata[0];
                A_BASE:  st_d.sh_base = wdata;
                default: ;
            endcase
            for (int i = 0; i < N_FIELDS; i++) begin
                if (addr == ADDR_W'(int'(A_TIM0) + i))
                    st_d.sh_tim[i] = wdata[CW-1:0];
            end
        end
        st_d.en     = ctrl_v[B_EN];
        st_d.sh_inv = ctrl_v[B_INVDE:B_INVH];
        st_d.srst   = ctrl_v[B_SRST];

        start = !st_q.run && st_q.en && !st_q.srst;
        fend  = st_q.run && frame_end;
        if (start) st_d.run = 1'b1;
        if (fend && !st_q.en) st_d.run = 1'b0;
        if ((start || fend) && st_q.load) begin
            st_d.lv_tim  = st_q.sh_tim;
            st_d.lv_inv  = st_q.sh_inv;
            st_d.lv_base = st_q.sh_base;
            st_d.load    = load_set;
        end else begin
            st_d.load    = st_q.load | load_set;
        end
        if (vblank) st_d.sticky = 1'b1;

        if (st_q.srst) begin
            st_d      = defaults();
            st_d.srst = ctrl_v[B_SRST];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= defaults();
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL, A_SET, A_CLR:
                rdata[CTRL_W-1:0] = {st_q.srst, st_q.sh_inv, st_q.load, st_q.run};
            A_STAT:  rdata[0] = st_q.sticky;
            A_IRQEN: rdata[0] = st_q.irq_en;
            A_BASE:  rdata = st_q.sh_base;
            default: ;
        endcase
        for (int i = 0; i < N_FIELDS; i++) begin
            if (addr == ADDR_W'(int'(A_TIM0) + i))
                rdata[CW-1:0] = st_q.sh_tim[i];
        end
    end

    assign live_tim  = st_q.lv_tim;
    assign live_inv  = st_q.lv_inv;
    assign live_base = st_q.lv_base;
    assign run       = st_q.run;
    assign srst      = st_q.srst;
    assign load_pend = st_q.load;
    assign sticky    = st_q.sticky;
    assign irq       = st_q.sticky & st_q.irq_en;
endmodule

// File: rtl/tg_counter.sv
module tg_counter
    import tg_pkg::*;
#(
    parameter int CW = 12,
    localparam int HW = CW + 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        run,
    input  logic [N_FIELDS-1:0][CW-1:0] tim,
    output logic [HW-1:0]               h,
    output logic [HW-1:0]               v,
    output logic                        frame_end,
    output logic                        vblank,
    output logic                        de_raw,
    output logic                        hs_raw,
    output logic                        vs_raw
);
    typedef struct packed {
        logic [HW-1:0] h;
        logic [HW-1:0] v;
    } cnt_t;

    cnt_t c_d, c_q;
    logic [HW-1:0] htot, vtot, hs_beg, vs_beg;
    logic line_end;

    always_comb begin
        htot   = HW'(tim[F_HACT]) + HW'(tim[F_HFP]) + HW'(tim[F_HSW]) + HW'(tim[F_HBP]);
        vtot   = HW'(tim[F_VACT]) + HW'(tim[F_VFP]) + HW'(tim[F_VSW]) + HW'(tim[F_VBP]);
        hs_beg = HW'(tim[F_HACT]) + HW'(tim[F_HFP]);
        vs_beg = HW'(tim[F_VACT]) + HW'(tim[F_VFP]);
        line_end = (c_q.h == htot - 1'b1);
        c_d = c_q;
        if (!run) begin
            c_d = '0;
        end else if (line_end) begin
            c_d.h = '0;
            c_d.v = (c_q.v == vtot - 1'b1) ? '0 : c_q.v + 1'b1;
        end else begin
            c_d.h = c_q.h + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign h         = c_q.h;
    assign v         = c_q.v;
    assign frame_end = run && line_end && (c_q.v == vtot - 1'b1);
    assign vblank    = run && (c_q.h == '0) && (c_q.v == HW'(tim[F_VACT]));
    assign de_raw    = run && (c_q.h < HW'(tim[F_HACT])) && (c_q.v < HW'(tim[F_VACT]));
    assign hs_raw    = run && (c_q.h >= hs_beg) && (c_q.h < hs_beg + HW'(tim[F_HSW]));
    assign vs_raw    = run && (c_q.v >= vs_beg) && (c_q.v < vs_beg + HW'(tim[F_VSW]));
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
    import tg_pkg::*;
#(
    parameter int CW       = 12,
    parameter int DW       = 32,
    parameter int DEF_HACT = 8,
    parameter int DEF_HFP  = 2,
    parameter int DEF_HSW  = 3,
    parameter int DEF_HBP  = 1,
    parameter int DEF_VACT = 3,
    parameter int DEF_VFP  = 1,
    parameter int DEF_VSW  = 2,
    parameter int DEF_VBP  = 1,
    localparam int HW      = CW + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic [HW-1:0]     pix_x,
    output logic [HW-1:0]     pix_y,
    output logic [DW-1:0]     frame_base,
    output logic              vblank,
    output logic              irq
);
    localparam logic [N_FIELDS-1:0][CW-1:0] DEF_TIM = {
        CW'(DEF_VBP), CW'(DEF_VSW), CW'(DEF_VFP), CW'(DEF_VACT),
        CW'(DEF_HBP), CW'(DEF_HSW), CW'(DEF_HFP), CW'(DEF_HACT)};

    logic [N_FIELDS-1:0][CW-1:0] live_tim;
    logic [2:0] live_inv;
    logic run, srst, load_pend, sticky, frame_end;
    logic de_raw, hs_raw, vs_raw;
    logic [HW-1:0] h, v;

    tg_regs #(.CW(CW), .DW(DW), .DEF_TIM(DEF_TIM)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (reg_we),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .frame_end (frame_end),
        .vblank    (vblank),
        .live_tim  (live_tim),
        .live_inv  (live_inv),
        .live_base (frame_base),
        .run       (run),
        .srst      (srst),
        .load_pend (load_pend),
        .sticky    (sticky),
        .irq       (irq)
    );

    tg_counter #(.CW(CW)) i_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .tim       (live_tim),
        .h         (h),
        .v         (v),
        .frame_end (frame_end),
        .vblank    (vblank),
        .de_raw    (de_raw),
        .hs_raw    (hs_raw),
        .vs_raw    (vs_raw)
    );

    assign hsync = hs_raw ^ live_inv[0];
    assign vsync = vs_raw ^ live_inv[1];
    assign de    = de_raw ^ live_inv[2];
    assign pix_x = h;
    assign pix_y = v;
endmodule

// File: rtl/tg_checker.sv
module tg_checker
    import tg_pkg::*;
#(
    parameter int CW = 12,
    localparam int HW = CW + 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        run,
    input logic                        frame_end,
    input logic                        srst,
    input logic                        load_pend,
    input logic                        vblank,
    input logic                        sticky,
    input logic                        de_raw,
    input logic [HW-1:0]               pix_x,
    input logic [N_FIELDS-1:0][CW-1:0] live_tim
);
    p_live_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run && !frame_end && !srst |=> $stable(live_tim));

    p_load_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_pend && run && !frame_end && !srst |=> load_pend);

    p_stop_frame_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run && !frame_end && !srst |=> run);

    p_vblank_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        vblank |=> !vblank);

    p_sticky_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        vblank && !srst |=> sticky);

    p_coord_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        de_raw |-> (pix_x < HW'(live_tim[F_HACT])));
endmodule

bind disp_timing_gen tg_checker #(.CW(CW)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .frame_end (frame_end),
    .srst      (srst),
    .load_pend (load_pend),
    .vblank    (vblank),
    .sticky    (sticky),
    .de_raw    (de_raw),
    .pix_x     (pix_x),
    .live_tim  (live_tim)
);

// File: tb/test_disp_timing_gen.sv
module test_disp_timing_gen;
    import tg_pkg::*;

    localparam int CW = 12;
    localparam int DW = 32;
    localparam int HW = CW + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic hsync, vsync, de, vblank, irq;
    logic [HW-1:0] pix_x, pix_y;
    logic [DW-1:0] frame_base;

    always #4 clk = ~clk;

    disp_timing_gen #(.CW(CW), .DW(DW)) i_disp_timing_gen (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hsync(hsync),
        .vsync(vsync), .de(de), .pix_x(pix_x), .pix_y(pix_y),
        .frame_base(frame_base), .vblank(vblank), .irq(irq));

    int checks = 0;
    int fails = 0;
    int cur[8];
    logic [2:0] cur_inv;
    int r_frame, r_de, r_hs, r_vs, r_line, r_hoff, r_vbl, r_mis;

    function automatic int f_htot(); return cur[0] + cur[1] + cur[2] + cur[3]; endfunction
    function automatic int f_vtot(); return cur[4] + cur[5] + cur[6] + cur[7]; endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DW-1:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [DW-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [DW-1:0] ctrl_word(input logic [2:0] inv, input bit load, input bit en);
        return {26'd0, 1'b0, inv, load, en};
    endfunction

    task automatic wait_vblank();
        int n = 0;
        tick();
        while (!vblank && n < 20000) begin tick(); n++; end
    endtask

    task automatic wait_load_clear(input string req);
        logic [DW-1:0] d;
        int n = 0;
        rd(A_CTRL, d);
        while (d[B_LOAD] && n < 20000) begin tick(); rd(A_CTRL, d); n++; end
        chk(req, "load bit self-clears", d[B_LOAD], 0);
    endtask

    task automatic measure();
        int cyc = 0, fall_at = -1, rise1 = -1, x_exp = 0, y_exp = -1;
        logic p_de = 1'b0, p_hs = 1'b0;
        logic d_r, h_r, v_r;
        r_frame = 0; r_de = 0; r_hs = 0; r_vs = 0; r_line = -1; r_hoff = -1; r_vbl = 0; r_mis = 0;
        wait_vblank();
        do begin
            d_r = de ^ cur_inv[2];
            h_r = hsync ^ cur_inv[0];
            v_r = vsync ^ cur_inv[1];
            if (vblank) r_vbl++;
            if (d_r) r_de++;
            if (h_r) r_hs++;
            if (v_r) r_vs++;
            if (d_r && !p_de) begin
                if (rise1 < 0) rise1 = cyc;
                else if (r_line < 0) r_line = cyc - rise1;
                x_exp = 0;
                y_exp++;
            end
            if (d_r) begin
                if (pix_x != HW'(x_exp) || pix_y != HW'(y_exp)) r_mis++;
                x_exp++;
            end
            if (!d_r && p_de) fall_at = cyc;
            if (h_r && !p_hs && fall_at >= 0 && r_hoff < 0) r_hoff = cyc - fall_at;
            p_de = d_r; p_hs = h_r;
            tick();
            cyc++;
        end while (!vblank && cyc < 20000);
        r_frame = cyc;
    endtask

    task automatic check_mode(input string tag);
        measure();
        chk("R2", {tag, " frame cycles"}, r_frame, f_htot() * f_vtot());
        chk("R1", {tag, " line period"}, r_line, f_htot());
        chk("R1/R3", {tag, " de cycles per frame"}, r_de, cur[0] * cur[4]);
        chk("R1", {tag, " hsync after de"}, r_hoff, cur[1]);
        chk("R1/R3", {tag, " hsync cycles"}, r_hs, cur[2] * f_vtot());
        chk("R2/R3", {tag, " vsync cycles"}, r_vs, cur[6] * f_htot());
        chk("R9", {tag, " vblank pulse width"}, r_vbl, 1);
        chk("R10", {tag, " coordinate mismatches"}, r_mis, 0);
    endtask

    task automatic prog(input logic [DW-1:0] base, input bit en);
        for (int i = 0; i < 8; i++) wr(ADDR_W'(int'(A_TIM0) + i), DW'(cur[i]));
        wr(A_BASE, base);
        wr(A_CTRL, ctrl_word(cur_inv, 1'b1, en));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [DW-1:0] d;
        int seed_dummy, cnt;
        seed_dummy = $urandom(32'd4242);
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // reset state
        rd(A_CTRL, d);   chk("R6", "ctrl after reset", d, 0);
        rd(A_TIM0, d);   chk("R4", "hact default read", d, 8);
        chk("R7", "idle de", de, 0);
        chk("R7", "idle hsync", hsync, 0);
        chk("R7", "idle vsync", vsync, 0);
        chk("R9", "irq after reset", irq, 0);

        // mode A, started together with a load
        cur = '{10, 3, 2, 4, 4, 2, 1, 3};
        cur_inv = 3'b000;
        prog(32'hA000_0000, 1'b1);
        wait_load_clear("R6");
        check_mode("modeA");
        chk("R4", "frame base after commit", frame_base, 32'hA000_0000);

        // status and interrupt
        rd(A_STAT, d);  chk("R9", "sticky set", d[0], 1);
        chk("R9", "irq masked", irq, 0);
        wr(A_IRQEN, 1);
        chk("R9", "irq enabled", irq, 1);
        wr(A_STAT, 1);
        rd(A_STAT, d);  chk("R9", "sticky cleared", d[0], 0);
        chk("R9", "irq after clear", irq, 0);
        wr(A_IRQEN, 0);

        // mid-frame shadow write without load
        wait_vblank();
        wr(A_TIM0, DW'(cur[0] + 3));
        wr(A_BASE, 32'hB000_0000);
        rd(A_TIM0, d);  chk("R4", "shadow readback", d, cur[0] + 3);
        check_mode("held");
        chk("R4", "frame base held", frame_base, 32'hA000_0000);
        wr(A_CTRL, ctrl_word(cur_inv, 1'b1, 1'b1));
        rd(A_CTRL, d);  chk("R5", "load pending", d[B_LOAD], 1);
        wr(A_CTRL, ctrl_word(cur_inv, 1'b0, 1'b1));
        rd(A_CTRL, d);  chk("R5", "zero write keeps load", d[B_LOAD], 1);
        wait_load_clear("R5");
        cur[0] = cur[0] + 3;
        check_mode("committed");
        chk("R4", "frame base committed", frame_base, 32'hB000_0000);

        // random modes while running
        for (int k = 0; k < 3; k++) begin
            cur[0] = 4 + int'($urandom % 13);
            cur[1] = 1 + int'($urandom % 4);
            cur[2] = 1 + int'($urandom % 4);
            cur[3] = 1 + int'($urandom % 4);
            cur[4] = 2 + int'($urandom % 5);
            cur[5] = 1 + int'($urandom % 3);
            cur[6] = 1 + int'($urandom % 3);
            cur[7] = 1 + int'($urandom % 3);
            cur_inv = 3'($urandom);
            prog(DW'($urandom), 1'b1);
            wait_load_clear("R5");
            check_mode($sformatf("rand%0d", k));
        end

        // disable during the vblank pulse
        wait_vblank();
        wr(A_CLR, 32'h1);
        cnt = 0;
        rd(A_CTRL, d);
        chk("R6", "enable still reads 1", d[B_EN], 1);
        while (d[B_EN] && cnt < 20000) begin cnt++; tick(); rd(A_CTRL, d); end
        chk("R6", "cycles until stop", cnt, (cur[5] + cur[6] + cur[7]) * f_htot() - 1);
        cnt = 0;
        for (int i = 0; i < 2 * f_htot(); i++) begin
            if (hsync != cur_inv[0] || vsync != cur_inv[1] || de != cur_inv[2] || vblank) cnt++;
            tick();
        end
        chk("R7/R3", "idle output level errors", cnt, 0);

        // soft reset through the set and clear aliases
        wr(A_SET, 32'h1);
        repeat (5) tick();
        wr(A_SET, 32'h1 << B_SRST);
        tick();
        rd(A_CTRL, d);   chk("R8", "ctrl during soft reset", d, 32'h20);
        rd(A_TIM0, d);   chk("R8", "hact back to default", d, 8);
        rd(A_BASE, d);   chk("R8", "base back to default", d, 0);
        chk("R8", "de idle in soft reset", de, 0);
        wr(A_CLR, 32'h1 << B_SRST);
        rd(A_CTRL, d);   chk("R8", "ctrl after clear alias", d, 0);
        wr(A_SET, 32'h1);
        cur = '{8, 2, 3, 1, 3, 1, 2, 1};
        cur_inv = 3'b000;
        check_mode("defaults");
        chk("R8", "frame base default", frame_base, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule